// File: doc/BRIEF.md
# Indirect Shared Register Window

This block gives a host a two-register window onto a separate bank of shared internal registers. The host sees a plain 32-bit register port with single-cycle write and read strobes. On the far side, the block issues one transaction at a time to a shared-bank port. That port is served by an arbiter outside the block. The window needs no handshake with the main MAC power domain, so it keeps working while that domain is down.

A command word written to the control register names a 16-bit shared-register offset and an operation. For a read, the host writes the command and then reads the data register. When the bank answers, the returned word is placed in the data register. For a write, the host first loads the data register with the value. It then writes the command, and that control write launches the bank write using the staged value. While a transaction is outstanding, the block lowers `host_ready`, and any host access waits until it rises again. The host read data is registered.

Top module: `shr_win_bridge`

## Requirements
- R1: After reset, the control and data registers read as zero, `host_ready` is high and `shr_req` is low.
- R2: A host write to the control offset (0xEC) stores the whole 32-bit word, and a later read of 0xEC returns that word unchanged. This includes bits [27:16] and [31:30].
- R3: A control word whose command field, bits [29:28], holds 0 or 1 issues no shared-bank request.
- R4: Command 2 (read) raises `shr_req` with `shr_we` low and `shr_addr` equal to bits [15:0] of the control word. Bits [27:16] and [31:30] do not affect the request.
- R5: When the bank answers a read with `shr_rvalid`, `shr_rdata` is loaded into the data register. A host read of the data offset (0xF4) then returns it.
- R6: Command 3 (write) raises `shr_req` with `shr_we` high, `shr_addr` equal to bits [15:0] and `shr_wdata` equal to the data register as staged before the command.
- R7: Once raised, `shr_req` stays high with `shr_addr`, `shr_we` and `shr_wdata` unchanged until a cycle in which `shr_gnt` is high.
- R8: From the cycle after a command is accepted until its transaction completes, `host_ready` is low. A host access presented meanwhile is held off and is taken only once `host_ready` returns, so none is lost.
- R9: Read data appears on `host_rdata` one cycle after the read is accepted. A read of any offset other than 0xEC and 0xF4 returns zero.
- R10: A host write to any offset other than 0xEC and 0xF4 changes neither window register and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe, taken when `host_ready` is high |
| host_rd_en | input | 1 | Host read strobe, taken when `host_ready` is high |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_ready | output | 1 | High when a host access can be taken |
| shr_req | output | 1 | Shared-bank request |
| shr_we | output | 1 | Request is a write |
| shr_addr | output | 16 | Shared-register offset |
| shr_wdata | output | 32 | Shared-bank write data |
| shr_gnt | input | 1 | Arbiter grant for the current request |
| shr_rvalid | input | 1 | Read data from the bank is valid |
| shr_rdata | input | 32 | Read data from the bank |

## Verification
The embedded assertions cover the properties that hold in every cycle. They check that a request keeps its fields until it is granted, and that `host_ready` stays low while a request is up. They check that a request starts only from an accepted command, that the data register changes only through a host write or a bank answer, and that the state is clean after reset. Some behaviours can only be shown by the bench scenarios against the shared-bank model. These are: a value staged and written really lands at the named offset and reads back; the ignored command bits and the no-op commands leave the bank untouched; and a host access issued during a long grant or answer delay is held and completed rather than lost.

// File: rtl/shr_win_pkg.sv
package shr_win_pkg;
  typedef enum logic [1:0] {
    CMD_NOP0 = 2'd0,
    CMD_NOP1 = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } shr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } shr_state_e;

  localparam int CMD_LSB = 28;
endpackage

// File: rtl/shr_win_regs.sv
module shr_win_regs #(
  parameter int HOST_AW  = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 'hEC,
  parameter int DATA_OFS = 'hF4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               idle_i,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  load_data_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               launch_o
);
  import shr_win_pkg::*;

  localparam logic [HOST_AW-1:0] CTRL_A = HOST_AW'(CTRL_OFS);
  localparam logic [HOST_AW-1:0] DATA_A = HOST_AW'(DATA_OFS);

  logic ctrl_wr, data_wr, rd_take;
  shr_cmd_e new_cmd;

  assign ctrl_wr  = wr_en_i && idle_i && (addr_i == CTRL_A);
  assign data_wr  = wr_en_i && idle_i && (addr_i == DATA_A);
  assign rd_take  = rd_en_i && idle_i;
  assign new_cmd  = shr_cmd_e'(wdata_i[CMD_LSB +: 2]);
  assign launch_o = ctrl_wr && (new_cmd == CMD_RD || new_cmd == CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
    end else if (ctrl_wr) begin
      ctrl_o <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
    end else if (load_i) begin
      data_o <= load_data_i;
    end else if (data_wr) begin
      data_o <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_take) begin
      if (addr_i == CTRL_A)      rdata_o <= ctrl_o;
      else if (addr_i == DATA_A) rdata_o <= data_o;
      else                       rdata_o <= '0;
    end
  end

  // R5: the data register moves only through a host write or a bank answer
  data_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> ($past(data_wr) || $past(load_i)));

  // R10
  ctrl_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> $past(wr_en_i && addr_i == CTRL_A));
endmodule

// File: rtl/shr_win_seq.sv
module shr_win_seq (
  input  logic clk,
  input  logic rst,
  input  logic launch_i,
  input  logic we_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  output logic idle_o,
  output logic req_o,
  output logic load_o
);
  import shr_win_pkg::*;

  shr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) state_d = ST_REQ;
      ST_REQ:  if (gnt_i)    state_d = we_i ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (rvalid_i) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign req_o  = (state_q == ST_REQ);
  assign load_o = (state_q == ST_WAIT) && rvalid_i;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !gnt_i) |=> req_o);

  // R3: a request only follows an accepted read or write command
  req_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(launch_i));
endmodule

// File: rtl/shr_win_bridge.sv
module shr_win_bridge #(
  parameter int HOST_AW  = 8,
  parameter int DATA_W   = 32,
  parameter int OFS_W    = 16,
  parameter int CTRL_OFS = 'hEC,
  parameter int DATA_OFS = 'hF4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_ready,
  output logic               shr_req,
  output logic               shr_we,
  output logic [OFS_W-1:0]   shr_addr,
  output logic [DATA_W-1:0]  shr_wdata,
  input  logic               shr_gnt,
  input  logic               shr_rvalid,
  input  logic [DATA_W-1:0]  shr_rdata
);
  import shr_win_pkg::*;

  logic [DATA_W-1:0] ctrl_q, data_q;
  logic launch, idle, load;

  shr_win_regs #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) regs_i (
    .clk(clk), .rst(rst),
    .wr_en_i(host_wr_en), .rd_en_i(host_rd_en),
    .addr_i(host_addr), .wdata_i(host_wdata),
    .idle_i(idle), .load_i(load), .load_data_i(shr_rdata),
    .rdata_o(host_rdata), .ctrl_o(ctrl_q), .data_o(data_q),
    .launch_o(launch)
  );

  shr_win_seq seq_i (
    .clk(clk), .rst(rst),
    .launch_i(launch), .we_i(shr_we),
    .gnt_i(shr_gnt), .rvalid_i(shr_rvalid),
    .idle_o(idle), .req_o(shr_req), .load_o(load)
  );

  assign host_ready = idle;
  assign shr_addr   = ctrl_q[OFS_W-1:0];
  assign shr_we     = (ctrl_q[CMD_LSB +: 2] == CMD_WR);
  assign shr_wdata  = data_q;

  // R7
  req_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (shr_req && !shr_gnt) |=> ($stable(shr_addr) && $stable(shr_we) && $stable(shr_wdata)));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    shr_req |-> !host_ready);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (host_ready && !shr_req && ctrl_q == '0 && data_q == '0));
endmodule

// File: tb/shr_win_bridge_tb_top.sv
module shr_win_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_WORDS = 1024;
  localparam logic [7:0] A_CTRL = 8'hEC;
  localparam logic [7:0] A_DATA = 8'hF4;

  logic clk = 0;
  logic rst = 1;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic host_ready, shr_req, shr_we;
  logic [15:0] shr_addr;
  logic [31:0] shr_wdata;
  logic shr_gnt = 0, shr_rvalid = 0;
  logic [31:0] shr_rdata = 0;

  int errors = 0, checks = 0, cycles = 0;
  int gnt_dly = 0, rd_dly = 0;
  int req_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shr_win_bridge dut_i (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready),
    .shr_req(shr_req), .shr_we(shr_we), .shr_addr(shr_addr),
    .shr_wdata(shr_wdata), .shr_gnt(shr_gnt),
    .shr_rvalid(shr_rvalid), .shr_rdata(shr_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shared bank model
  logic [31:0] mem [BANK_WORDS];
  int gcnt = 0, rcnt = 0;
  bit rpend = 0;
  logic [31:0] rhold;

  always @(posedge clk) begin
    if (shr_req && shr_gnt) begin
      req_count++;
      if (shr_we) begin
        if (shr_addr < BANK_WORDS) mem[shr_addr] = shr_wdata;
      end else begin
        rpend = 1;
        rcnt  = rd_dly;
        rhold = (shr_addr < BANK_WORDS) ? mem[shr_addr] : 32'h0;
      end
    end
  end

  always @(negedge clk) begin
    if (shr_req) begin
      shr_gnt = (gcnt >= gnt_dly);
      gcnt++;
    end else begin
      shr_gnt = 0;
      gcnt = 0;
    end
    shr_rvalid = 0;
    if (rpend) begin
      if (rcnt == 0) begin
        shr_rvalid = 1;
        shr_rdata  = rhold;
        rpend = 0;
      end else rcnt--;
    end
  end

  // cycle-by-cycle reference model
  int m_phase = 0;
  logic [31:0] m_ctrl = 0, m_data = 0, m_rd = 0;
  bit m_rd_due = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_ctrl = 0; m_data = 0; m_rd_due = 0;
    end else begin
      m_rd_due = 0;
      case (m_phase)
        0: begin
          if (host_rd_en) begin
            m_rd = (host_addr == A_CTRL) ? m_ctrl : (host_addr == A_DATA) ? m_data : 32'h0;
            m_rd_due = 1;
          end
          if (host_wr_en && host_addr == A_CTRL) begin
            m_ctrl = host_wdata;
            if (host_wdata[29]) m_phase = 1;
          end else if (host_wr_en && host_addr == A_DATA) begin
            m_data = host_wdata;
          end
        end
        1: if (shr_gnt) m_phase = (m_ctrl[29:28] == 2'd3) ? 0 : 2;
        default: if (shr_rvalid) begin m_data = shr_rdata; m_phase = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R8 ready", host_ready, m_phase == 0);
      check("R7 req", shr_req, m_phase == 1);
      if (m_phase == 1) begin
        check("R4 addr", shr_addr, m_ctrl[15:0]);
        check("R6 we", shr_we, m_ctrl[29:28] == 2'd3);
        if (m_ctrl[29:28] == 2'd3) check("R6 wdata", shr_wdata, m_data);
      end
      if (m_rd_due) check("R9 rdata", host_rdata, m_rd);
    end
  end

  // host tasks
  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d, output int stall);
    host_addr = a; host_rd_en = 1; stall = 0;
    while (!host_ready) begin @(negedge clk); stall++; end
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  task automatic idle_wait();
    while (!host_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int st, rq0;
    logic [31:0] v;
    for (int i = 0; i < BANK_WORDS; i++) mem[i] = 32'h5000_0000 + i;
    repeat (3) @(negedge clk);
    // R1
    check("R1 ready", host_ready, 1);
    check("R1 req", shr_req, 0);
    rst = 0;
    hread(A_CTRL, v, st); check("R1 ctrl", v, 0);
    hread(A_DATA, v, st); check("R1 data", v, 0);

    // R2 / R3: nop commands store the word, issue nothing
    rq0 = req_count;
    hwrite(A_CTRL, 32'hC0AB_11C0);
    repeat (3) @(negedge clk);
    hread(A_CTRL, v, st); check("R2 ctrl readback", v, 32'hC0AB_11C0);
    hwrite(A_CTRL, 32'h9FFF_01DC);
    repeat (3) @(negedge clk);
    check("R3 no request", req_count, rq0);
    check("R3 bank untouched", mem[16'h1DC], 32'h5000_01DC);

    // R6 / R7: staged write with grant delay, junk in ignored bits
    gnt_dly = 3;
    hwrite(A_DATA, 32'hA5A5_1234);
    hwrite(A_CTRL, 32'hF123_01DC);
    idle_wait();
    check("R6 bank write 1DC", mem[16'h1DC], 32'hA5A5_1234);

    // R4 / R5: read back through the window
    rd_dly = 2;
    hwrite(A_DATA, 32'h0);
    hwrite(A_CTRL, 32'h6ABC_01DC);
    hread(A_DATA, v, st);
    check("R5 read 1DC", v, 32'hA5A5_1234);
    check("R8 read stalled", st > 0, 1);

    // other offsets, varied delays
    gnt_dly = 0; rd_dly = 0;
    hwrite(A_DATA, 32'h0000_C1C0);
    hwrite(A_CTRL, 32'h3000_01C0);
    hwrite(A_DATA, 32'h0000_C1C4);
    hwrite(A_CTRL, 32'h3000_01C4);
    hwrite(A_CTRL, 32'h2000_01C4);
    hread(A_DATA, v, st); check("R5 read 1C4", v, 32'h0000_C1C4);
    rd_dly = 6; gnt_dly = 2;
    hwrite(A_CTRL, 32'h2000_01C0);
    hread(A_DATA, v, st); check("R5 read 1C0 long", v, 32'h0000_C1C0);
    hwrite(A_CTRL, 32'h2000_0005);
    hread(A_DATA, v, st); check("R4 untouched reg", v, 32'h5000_0005);

    // R8: back-to-back control writes, second held off
    gnt_dly = 4; rd_dly = 0;
    hwrite(A_DATA, 32'h1111_2222);
    hwrite(A_CTRL, 32'h3000_0100);
    hwrite(A_CTRL, 32'h3000_0101);
    idle_wait();
    check("R8 first write", mem[16'h100], 32'h1111_2222);
    check("R8 second write", mem[16'h101], 32'h1111_2222);

    // R9 / R10: unknown offsets
    hread(8'h10, v, st); check("R9 unknown read", v, 0);
    rq0 = req_count;
    hwrite(8'h10, 32'h3000_0200);
    hwrite(8'hF0, 32'hDEAD_BEEF);
    hread(A_CTRL, v, st); check("R10 ctrl kept", v, 32'h3000_0101);
    hread(A_DATA, v, st); check("R10 data kept", v, 32'h1111_2222);
    check("R10 no request", req_count, rq0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule